// File: doc/BRIEF.md
# Pipelined Three-Product Complex Multiplier

This block multiplies two signed complex numbers, x = a_re + j·a_im and y = b_re + j·b_im. Each of the four parts is an `IN_W`-bit two's-complement value. The block returns the real part a_re·b_re − a_im·b_im and the imaginary part a_re·b_im + a_im·b_re. It forms only three real products: the product of the two operand sums, a_re·b_re, and a_im·b_im. The real part is the difference of the last two. The imaginary part is the sum-product less both of the others.

The block is a three-stage pipeline with no backpressure, and it accepts a new operand pair on every clock. The stages are a registered pre-add, registered products and a registered subtract network. A qualifier travels beside the data and marks each result.

At full precision (`OUT_W` = 2·`IN_W`+1) the outputs are exact. A smaller `OUT_W` keeps only the upper bits of each exact result.

Top module: `cmul3_pipe`

## Requirements
- R1: When out_valid is high, out_re holds a_re·b_re − a_im·b_im of the operands accepted three cycles earlier. This is an exact signed value of 2·IN_W+1 bits when OUT_W = 2·IN_W+1.
- R2: When out_valid is high, out_im holds a_re·b_im + a_im·b_re of the same operands, with the same width rule as R1.
- R3: With all four parts at the most negative value (−128 for IN_W = 8), the full-precision outputs are out_re = 0 and out_im = +32768. That imaginary value is positive in 17 bits and does not wrap.
- R4: out_valid is high in a cycle exactly when in_valid was high three cycles earlier. Operands may be presented on every consecutive cycle.
- R5: Data presented while in_valid is low is ignored. While out_valid is low, out_re and out_im keep their last values.
- R6: While rst_n is low, out_valid is low, and operands in flight at reset produce no output. The result registers are not cleared by reset.
- R7: With OUT_W < 2·IN_W+1, each output equals its exact result shifted arithmetically right by 2·IN_W+1−OUT_W bits (floor truncation). The bits kept are the upper ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands on a_*/b_* are accepted this cycle |
| a_re | input | IN_W | Real part of first operand, two's complement |
| a_im | input | IN_W | Imaginary part of first operand |
| b_re | input | IN_W | Real part of second operand |
| b_im | input | IN_W | Imaginary part of second operand |
| out_valid | output | 1 | out_re/out_im carry a new result this cycle |
| out_re | output | OUT_W | Real part of the product, upper OUT_W bits |
| out_im | output | OUT_W | Imaginary part of the product, upper OUT_W bits |

## Verification
The assertions assume that rst_n is released away from a rising edge. They also assume that the operand parts are known whenever in_valid is high. Result checks start only once three edges have passed since reset release, because the latency window would otherwise reach back into reset. The stimulus changes every input on the falling edge and releases reset there. It keeps the operands at defined values throughout, including the idle gaps, where the values are random and must not leak to the outputs.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;
  // Number of register stages between operand capture and result.
  localparam int unsigned PIPE_STAGES = 3;
  // Number of real products formed per complex multiply.
  localparam int unsigned NUM_PROD    = 3;
  // Product lane assignment (the post stage decodes these lanes).
  localparam int unsigned P_SUM = 0;  // (a_re+a_im)*(b_re+b_im)
  localparam int unsigned P_AC  = 1;  // a_re*b_re
  localparam int unsigned P_BD  = 2;  // a_im*b_im
endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd
  import cmul3_pkg::*;
#(
  parameter  int unsigned IN_W  = 8,
  localparam int unsigned SUM_W = IN_W + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [IN_W-1:0]                  a_re,
  input  logic [IN_W-1:0]                  a_im,
  input  logic [IN_W-1:0]                  b_re,
  input  logic [IN_W-1:0]                  b_im,
  output logic                             vld_o,
  output logic [NUM_PROD-1:0][SUM_W-1:0]   x_o,
  output logic [NUM_PROD-1:0][SUM_W-1:0]   y_o
);

  logic [NUM_PROD-1:0][SUM_W-1:0] x_d;
  logic [NUM_PROD-1:0][SUM_W-1:0] y_d;
  logic                           vld_d;

  // Next state: sign-extend each part and form the two operand sums.
  always_comb begin
    x_d[P_SUM] = SUM_W'($signed(a_re)) + SUM_W'($signed(a_im));
    y_d[P_SUM] = SUM_W'($signed(b_re)) + SUM_W'($signed(b_im));
    x_d[P_AC]  = SUM_W'($signed(a_re));
    y_d[P_AC]  = SUM_W'($signed(b_re));
    x_d[P_BD]  = SUM_W'($signed(a_im));
    y_d[P_BD]  = SUM_W'($signed(b_im));
    vld_d      = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_d;
    end
  end

  // Data registers: no reset, loaded only on an accepted operand.
  always_ff @(posedge clk) begin
    if (in_valid) begin
      x_o <= x_d;
      y_o <= y_d;
    end
  end

endmodule

// File: rtl/cmul3_prod.sv
module cmul3_prod
  import cmul3_pkg::*;
#(
  parameter  int unsigned IN_W   = 8,
  localparam int unsigned SUM_W  = IN_W + 1,
  localparam int unsigned PROD_W = 2 * SUM_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             vld_i,
  input  logic [NUM_PROD-1:0][SUM_W-1:0]   x_i,
  input  logic [NUM_PROD-1:0][SUM_W-1:0]   y_i,
  output logic                             vld_o,
  output logic [NUM_PROD-1:0][PROD_W-1:0]  p_o
);

  // One signed multiplier lane per product.
  for (genvar g = 0; g < NUM_PROD; g++) begin : g_lane
    logic signed [PROD_W-1:0] p_d;
    logic        [PROD_W-1:0] p_q;

    always_comb begin
      p_d = $signed(x_i[g]) * $signed(y_i[g]);
    end

    always_ff @(posedge clk) begin
      if (vld_i) begin
        p_q <= p_d;
      end
    end

    assign p_o[g] = p_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
  end

endmodule

// File: rtl/cmul3_post.sv
module cmul3_post
  import cmul3_pkg::*;
#(
  parameter  int unsigned IN_W   = 8,
  parameter  int unsigned OUT_W  = 2 * IN_W + 1,
  localparam int unsigned PROD_W = 2 * (IN_W + 1),
  localparam int unsigned FULL_W = 2 * IN_W + 1,
  localparam int unsigned DROP   = FULL_W - OUT_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             vld_i,
  input  logic [NUM_PROD-1:0][PROD_W-1:0]  p_i,
  output logic                             vld_o,
  output logic [OUT_W-1:0]                 re_o,
  output logic [OUT_W-1:0]                 im_o
);

  logic [PROD_W-1:0] diff_re;
  logic [PROD_W-1:0] diff_im;
  logic [FULL_W-1:0] re_full;
  logic [FULL_W-1:0] im_full;
  logic [OUT_W-1:0]  re_d;
  logic [OUT_W-1:0]  im_d;

  // Subtract network: exact results fit FULL_W bits, top bit is redundant.
  always_comb begin
    diff_re = p_i[P_AC] - p_i[P_BD];
    diff_im = p_i[P_SUM] - p_i[P_AC] - p_i[P_BD];
    re_full = diff_re[FULL_W-1:0];
    im_full = diff_im[FULL_W-1:0];
  end

  logic unused_msb;
  assign unused_msb = diff_re[PROD_W-1] ^ diff_im[PROD_W-1];

  // Precision variant: full width passes through, otherwise keep upper bits.
  if (DROP == 0) begin : g_full
    assign re_d = re_full;
    assign im_d = im_full;
  end else begin : g_trunc
    logic unused_low;
    assign unused_low = ^{re_full[DROP-1:0], im_full[DROP-1:0]};
    assign re_d = re_full[FULL_W-1 -: OUT_W];
    assign im_d = im_full[FULL_W-1 -: OUT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_i) begin
      re_o <= re_d;
      im_o <= im_d;
    end
  end

endmodule

// File: rtl/cmul3_pipe.sv
module cmul3_pipe
  import cmul3_pkg::*;
#(
  parameter  int unsigned IN_W   = 8,
  parameter  int unsigned OUT_W  = 2 * IN_W + 1,
  localparam int unsigned SUM_W  = IN_W + 1,
  localparam int unsigned PROD_W = 2 * SUM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   a_re,
  input  logic [IN_W-1:0]   a_im,
  input  logic [IN_W-1:0]   b_re,
  input  logic [IN_W-1:0]   b_im,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_re,
  output logic [OUT_W-1:0]  out_im
);

  logic                            s1_vld;
  logic [NUM_PROD-1:0][SUM_W-1:0]  s1_x;
  logic [NUM_PROD-1:0][SUM_W-1:0]  s1_y;
  logic                            s2_vld;
  logic [NUM_PROD-1:0][PROD_W-1:0] s2_p;

  cmul3_preadd #(.IN_W(IN_W)) u_preadd (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .a_re     (a_re),
    .a_im     (a_im),
    .b_re     (b_re),
    .b_im     (b_im),
    .vld_o    (s1_vld),
    .x_o      (s1_x),
    .y_o      (s1_y)
  );

  cmul3_prod #(.IN_W(IN_W)) u_prod (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (s1_vld),
    .x_i   (s1_x),
    .y_i   (s1_y),
    .vld_o (s2_vld),
    .p_o   (s2_p)
  );

  cmul3_post #(.IN_W(IN_W), .OUT_W(OUT_W)) u_post (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (s2_vld),
    .p_i   (s2_p),
    .vld_o (out_valid),
    .re_o  (out_re),
    .im_o  (out_im)
  );

endmodule

// File: rtl/cmul3_pipe_chk.sv
module cmul3_pipe_chk #(
  parameter  int unsigned IN_W   = 8,
  parameter  int unsigned OUT_W  = 2 * IN_W + 1,
  localparam int unsigned FULL_W = 2 * IN_W + 1,
  localparam int unsigned SH     = FULL_W - OUT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [IN_W-1:0]   a_re,
  input logic [IN_W-1:0]   a_im,
  input logic [IN_W-1:0]   b_re,
  input logic [IN_W-1:0]   b_im,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_re,
  input logic [OUT_W-1:0]  out_im
);

  localparam logic [IN_W-1:0] MOST_NEG = {1'b1, {(IN_W-1){1'b0}}};

  logic [1:0] since_rst;
  logic       seen_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 2'd0;
      seen_out  <= 1'b0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      if (out_valid)         seen_out  <= 1'b1;
    end
  end

  // Direct four-product reference of the current inputs.
  logic signed [FULL_W:0] ref_re;
  logic signed [FULL_W:0] ref_im;
  logic [OUT_W-1:0]       exp_re;
  logic [OUT_W-1:0]       exp_im;
  logic                   all_neg;

  assign ref_re  = $signed(a_re) * $signed(b_re) - $signed(a_im) * $signed(b_im);
  assign ref_im  = $signed(a_re) * $signed(b_im) + $signed(a_im) * $signed(b_re);
  assign exp_re  = OUT_W'(ref_re >>> SH);
  assign exp_im  = OUT_W'(ref_im >>> SH);
  assign all_neg = (a_re == MOST_NEG) && (a_im == MOST_NEG) &&
                   (b_re == MOST_NEG) && (b_im == MOST_NEG);

  AST_RST_QUIET: assert property (@(posedge clk)
    !rst_n |=> !out_valid);  // R6

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));  // R4

  AST_RE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && out_valid) |-> (out_re == $past(exp_re, 3)));  // R1 R7

  AST_IM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && out_valid) |-> (out_im == $past(exp_im, 3)));  // R2 R7

  AST_CORNER_ZERO_RE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && out_valid && $past(all_neg, 3)) |-> (out_re == '0));  // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_out && !out_valid) |-> ($stable(out_re) && $stable(out_im)));  // R5

endmodule

bind cmul3_pipe cmul3_pipe_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .a_re      (a_re),
  .a_im      (a_im),
  .b_re      (b_re),
  .b_im      (b_im),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/cmul3_pipe_bench.sv
module cmul3_pipe_bench;

  localparam int IN_W   = 8;
  localparam int FULL_W = 2 * IN_W + 1;
  localparam int TW     = 9;
  localparam int SH     = FULL_W - TW;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic                   rst_n;
  logic                   in_valid;
  logic signed [IN_W-1:0] a_re, a_im, b_re, b_im;
  logic                   ov_f, ov_t;
  logic [FULL_W-1:0]      re_f, im_f;
  logic [TW-1:0]          re_t, im_t;

  cmul3_pipe #(.IN_W(IN_W)) u_cmul3_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(ov_f), .out_re(re_f), .out_im(im_f)
  );

  cmul3_pipe #(.IN_W(IN_W), .OUT_W(TW)) u_cmul3_pipe_t9 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(ov_t), .out_re(re_t), .out_im(im_t)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit run   = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: queue of accepted samples, three-cycle latency.
  typedef struct { bit v; int re; int im; } ent_t;
  ent_t q[$];
  bit   exp_v = 1'b0;
  int   exp_re, exp_im;
  bit   have = 1'b0;

  task automatic q_flush();
    ent_t z;
    z.v = 1'b0; z.re = 0; z.im = 0;
    q.delete();
    q.push_back(z);
    q.push_back(z);
  endtask

  initial q_flush();

  always @(posedge clk) begin
    ent_t n, e;
    if (!rst_n) begin
      q_flush();
      exp_v = 1'b0;
    end else begin
      n.v  = in_valid;
      n.re = int'(a_re) * int'(b_re) - int'(a_im) * int'(b_im);
      n.im = int'(a_re) * int'(b_im) + int'(a_im) * int'(b_re);
      q.push_back(n);
      e = q.pop_front();
      exp_v = e.v;
      if (e.v) begin
        exp_re = e.re;
        exp_im = e.im;
        have   = 1'b1;
      end
    end
  end

  // Compare every clock, a quarter period after the rising edge.
  always @(posedge clk) begin
    #5;
    if (run) begin
      check(rst_n ? "R4" : "R6", "out_valid", int'(ov_f), int'(exp_v));
      check(rst_n ? "R4" : "R6", "out_valid_t", int'(ov_t), int'(exp_v));
      if (have) begin
        check(exp_v ? "R1" : "R5", "out_re", int'($signed(re_f)), exp_re);
        check(exp_v ? "R2" : "R5", "out_im", int'($signed(im_f)), exp_im);
        check("R7", "out_re_t", int'($signed(re_t)), exp_re >>> SH);
        check("R7", "out_im_t", int'($signed(im_t)), exp_im >>> SH);
      end
    end
  end

  task automatic drive_rand(input bit v);
    in_valid = v;
    a_re = 8'($urandom);
    a_im = 8'($urandom);
    b_re = 8'($urandom);
    b_im = 8'($urandom);
  endtask

  // One isolated multiply with an explicit expectation three cycles later.
  task automatic one_shot(input int ar, input int ai, input int br, input int bi, input string req);
    int er, ei;
    er = ar * br - ai * bi;
    ei = ar * bi + ai * br;
    @(negedge clk);
    in_valid = 1'b1;
    a_re = 8'(ar); a_im = 8'(ai); b_re = 8'(br); b_im = 8'(bi);
    @(posedge clk);
    @(negedge clk);
    drive_rand(1'b0);
    @(posedge clk);
    @(posedge clk);
    #5;
    check(req, "shot_valid", int'(ov_f), 1);
    check(req, "shot_re", int'($signed(re_f)), er);
    check(req, "shot_im", int'($signed(im_f)), ei);
    check("R7", "shot_re_t", int'($signed(re_t)), er >>> SH);
    check("R7", "shot_im_t", int'($signed(im_t)), ei >>> SH);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    a_re = '0; a_im = '0; b_re = '0; b_im = '0;
    repeat (3) @(posedge clk);
    #5;
    check("R6", "reset out_valid", int'(ov_f), 0);
    check("R6", "reset out_valid_t", int'(ov_t), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;

    // R3: all parts most negative; real part zero, imaginary +32768.
    one_shot(-128, -128, -128, -128, "R3");
    one_shot(127, 127, 127, 127, "R1");
    one_shot(-128, 127, 127, -128, "R2");
    one_shot(-128, -128, 127, 127, "R3");
    one_shot(0, -1, 1, 0, "R2");

    // R4: back-to-back operands on every cycle.
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      drive_rand(1'b1);
    end

    // R5: sparse valid with garbage on the data inputs in between.
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      drive_rand(($urandom % 3) == 0);
    end

    // R6: reset with operands in flight; nothing emerges, data held.
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      drive_rand(1'b1);
    end
    @(negedge clk);
    drive_rand(1'b0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      drive_rand(($urandom % 2) == 0);
    end
    @(negedge clk);
    drive_rand(1'b0);
    repeat (6) @(negedge clk);

    run = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #4_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule